// File: doc/BRIEF.md
# Watermark Secure Region Classifier

This block sorts bus addresses into secure and non-secure space for two memory regions: an on-chip SRAM and a main flash. The base and last addresses of each region are fixed at build time through parameters. The position of the secure/non-secure boundary inside each region comes from a programmable watermark input. The secure part always starts at the region base and spans (watermark + 1) granules. A granule is 1 KB for SRAM and 8 KB for flash.

A requester presents an address with a valid strobe. One clock later the block returns a valid strobe, a flag saying whether the address lies in either region, and the secure verdict. The watermark inputs are sampled in the same cycle as the address. A new value therefore applies to the very next request. Storage of the watermarks, their protection and the raising of bus errors are left to the surrounding logic.

Top module: `wmc_classifier`

## Requirements
- R1: For an SRAM address below base + ((sram_wm_i + 1) << 10), the response reports in-region 1 and secure 1.
- R2: For an SRAM address from base + ((sram_wm_i + 1) << 10) up to the SRAM last address, the response reports in-region 1 and secure 0.
- R3: For a flash address below base + ((flash_wm_i + 1) << 13), the response reports in-region 1 and secure 1. Flash granules are 8 KB.
- R4: For a flash address from base + ((flash_wm_i + 1) << 13) up to the flash last address, the response reports in-region 1 and secure 0.
- R5: A watermark of 0 leaves exactly the first granule of that region secure, so the secure part is never empty.
- R6: When the computed boundary lies at or beyond the region's last address, every address of that region is reported secure, with no wrap or overflow of the boundary arithmetic.
- R7: An address outside both regions is reported with in-region 0 and secure 0. The secure output is never 1 while in-region is 0.
- R8: A request with req_valid_i high in cycle N yields rsp_valid_o high in cycle N+1. A cycle with no request yields rsp_valid_o, rsp_in_region_o and rsp_secure_o all 0 in the next cycle.
- R9: While rst_n is low, all three outputs are 0.
- R10: The watermarks are sampled in the request cycle. Back-to-back requests to the same address with different watermarks each get the verdict for their own watermark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sram_wm_i | input | 8 | SRAM watermark, in 1 KB granules minus one |
| flash_wm_i | input | 7 | Flash watermark, in 8 KB granules minus one |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Address to classify |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_in_region_o | output | 1 | Address lies in SRAM or flash |
| rsp_secure_o | output | 1 | Address lies in a secure part |

## Verification
The assertions check several rules on every cycle:
- the one-cycle response timing and the quiet outputs in idle cycles;
- that a secure verdict never appears without an in-region hit;
- that the first granule of each region is always secure;
- that the last address of a region is secure whenever the boundary covers the whole region.

The exact boundary position for a given watermark can only be shown by the bench's scenarios. So can the non-secure side just above it, the treatment of addresses just outside each region, and the pairing of back-to-back watermark changes with their own requests.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

  // one classification result
  typedef struct packed {
    logic hit;
    logic secure;
  } verdict_t;

  localparam int unsigned ADDR_W_DEF    = 32;
  localparam int unsigned SRAM_WM_W_DEF = 8;
  localparam int unsigned FLSH_WM_W_DEF = 7;
  localparam int unsigned SRAM_GRAN_DEF = 10;
  localparam int unsigned FLSH_GRAN_DEF = 13;

  // merge two region verdicts; regions are disjoint, SRAM checked first
  function automatic verdict_t merge_verdict(input verdict_t a, input verdict_t b);
    verdict_t r;
    r.hit    = a.hit | b.hit;
    r.secure = a.hit ? a.secure : (b.hit ? b.secure : 1'b0);
    return r;
  endfunction

endpackage

// File: rtl/wmc_region.sv
module wmc_region #(
  parameter int unsigned      ADDR_W  = 32,
  parameter int unsigned      WM_W    = 8,
  parameter int unsigned      GRAN_LG = 10,
  parameter logic [ADDR_W-1:0] BASE   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] LAST   = 32'h2001_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WM_W-1:0]   wm_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wmc_pkg::verdict_t verdict_o
);
  // width of the secure span: (2^WM_W) granules needs one extra bit
  localparam int unsigned OFF_W = WM_W + GRAN_LG + 1;
  localparam int unsigned CMP_W = (ADDR_W > OFF_W) ? ADDR_W : OFF_W;
  localparam logic [OFF_W-1:0] ONE_G = 1;
  localparam logic [ADDR_W-1:0] REGION_TOP = LAST - BASE;

  // secure span in bytes for a watermark
  function automatic logic [OFF_W-1:0] span_of(input logic [WM_W-1:0] wm);
    logic [OFF_W-1:0] t;
    t = '0;
    t[WM_W-1:0] = wm;
    t = t + ONE_G;
    return t << GRAN_LG;
  endfunction

  logic [ADDR_W-1:0] offset;
  logic [CMP_W-1:0]  off_ext, span_ext, top_ext;
  logic              in_rng;
  logic              below_mark;
  logic              first_granule;
  logic              mark_covers_all;

  always_comb begin
    offset   = addr_i - BASE;
    off_ext  = '0;
    span_ext = '0;
    top_ext  = '0;
    off_ext[ADDR_W-1:0] = offset;
    span_ext[OFF_W-1:0] = span_of(wm_i);
    top_ext[ADDR_W-1:0] = REGION_TOP;
  end

  assign in_rng          = (addr_i >= BASE) && (addr_i <= LAST);
  assign below_mark      = off_ext < span_ext;
  assign first_granule   = in_rng && (off_ext[CMP_W-1:GRAN_LG] == '0);
  assign mark_covers_all = span_ext > top_ext;

  assign verdict_o.hit    = in_rng;
  assign verdict_o.secure = in_rng & below_mark;

  AST_FIRST_GRANULE_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    first_granule |-> verdict_o.secure);  // R5
  AST_SECURE_INSIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o.secure |-> verdict_o.hit);  // R7
  AST_FULL_COVER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_covers_all && addr_i == LAST) |-> verdict_o.secure);  // R6
endmodule

// File: rtl/wmc_out_stage.sv
module wmc_out_stage (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  wmc_pkg::verdict_t verdict_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic              secure_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      hit_o    <= 1'b0;
      secure_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      hit_o    <= valid_i & verdict_i.hit;
      secure_o <= valid_i & verdict_i.secure;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !hit_o && !secure_o));  // R8
  AST_SECURE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    secure_o |-> (hit_o && valid_o));  // R7
endmodule

// File: rtl/wmc_classifier.sv
module wmc_classifier #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       SRAM_WM_W  = 8,
  parameter int unsigned       FLSH_WM_W  = 7,
  parameter int unsigned       SRAM_GRAN  = 10,
  parameter int unsigned       FLSH_GRAN  = 13,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] SRAM_LAST  = 32'h2001_FFFF,
  parameter logic [ADDR_W-1:0] FLSH_BASE  = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] FLSH_LAST  = 32'h100F_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRAM_WM_W-1:0] sram_wm_i,
  input  logic [FLSH_WM_W-1:0] flash_wm_i,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_in_region_o,
  output logic                 rsp_secure_o
);
  import wmc_pkg::*;

  verdict_t sram_v, flash_v, merged_v;

  wmc_region #(
    .ADDR_W(ADDR_W), .WM_W(SRAM_WM_W), .GRAN_LG(SRAM_GRAN),
    .BASE(SRAM_BASE), .LAST(SRAM_LAST)
  ) u_sram (
    .clk(clk), .rst_n(rst_n), .wm_i(sram_wm_i),
    .addr_i(req_addr_i), .verdict_o(sram_v)
  );

  wmc_region #(
    .ADDR_W(ADDR_W), .WM_W(FLSH_WM_W), .GRAN_LG(FLSH_GRAN),
    .BASE(FLSH_BASE), .LAST(FLSH_LAST)
  ) u_flash (
    .clk(clk), .rst_n(rst_n), .wm_i(flash_wm_i),
    .addr_i(req_addr_i), .verdict_o(flash_v)
  );

  assign merged_v = merge_verdict(sram_v, flash_v);

  wmc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .valid_i(req_valid_i), .verdict_i(merged_v),
    .valid_o(rsp_valid_o), .hit_o(rsp_in_region_o), .secure_o(rsp_secure_o)
  );

  AST_REGIONS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_v.hit && flash_v.hit));  // R7
endmodule

// File: tb/wmc_classifier_test.sv
module wmc_classifier_test;
  localparam longint SB = 64'h2000_0000, SL = 64'h2001_FFFF;
  localparam longint FB = 64'h1000_0000, FL = 64'h100F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sram_wm = 8'hFF;
  logic [6:0]  flash_wm = 7'h7F;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_sec;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic  hit;
    logic  sec;
    string tag;
    logic [31:0] addr;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  wmc_classifier uut (
    .clk(clk), .rst_n(rst_n), .sram_wm_i(sram_wm), .flash_wm_i(flash_wm),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_in_region_o(rsp_hit), .rsp_secure_o(rsp_sec)
  );

  // reference: secure limit is base plus (wm+1) whole granules in bytes
  function automatic exp_t model(input logic [31:0] a, input logic [7:0] sw,
                                 input logic [6:0] fw, input string tag);
    exp_t e;
    longint ad = longint'(a);
    longint slim = SB + (longint'(sw) + 1) * 1024;
    longint flim = FB + (longint'(fw) + 1) * 8192;
    e.tag = tag; e.addr = a;
    if (ad >= SB && ad <= SL) begin e.hit = 1; e.sec = (ad < slim); end
    else if (ad >= FB && ad <= FL) begin e.hit = 1; e.sec = (ad < flim); end
    else begin e.hit = 0; e.sec = 0; end
    return e;
  endfunction

  task automatic send(input logic [31:0] a, input logic [7:0] sw,
                      input logic [6:0] fw, input string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; sram_wm = sw; flash_wm = fw;
    q.push_back(model(a, sw, fw, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // monitor: compare each response against the queued expectation
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        if (rsp_valid) begin
          exp_t e;
          checks++;
          if (q.size() == 0) begin
            fails++;
            $display("FAIL R8: response with no request pending, got valid=1 expected 0");
          end else begin
            e = q.pop_front();
            if (rsp_hit !== e.hit || rsp_sec !== e.sec) begin
              fails++;
              $display("FAIL %s: addr %h got hit=%b sec=%b expected hit=%b sec=%b",
                       e.tag, e.addr, rsp_hit, rsp_sec, e.hit, e.sec);
            end
          end
        end else begin
          checks++;  // R8 idle cycle: all outputs quiet, nothing owed
          if (rsp_hit !== 1'b0 || rsp_sec !== 1'b0 || q.size() != 0) begin
            fails++;
            $display("FAIL R8: idle got hit=%b sec=%b pending=%0d expected 0 0 0",
                     rsp_hit, rsp_sec, q.size());
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5677;
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R9 outputs held low in reset
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_sec !== 0) begin
      fails++;
      $display("FAIL R9: reset got %b%b%b expected 000", rsp_valid, rsp_hit, rsp_sec);
    end
    @(negedge clk); rst_n = 1;
    idle(2);

    // R1/R2: SRAM, watermark 3 -> secure below 0x2000_1000
    send(32'h2000_0000, 8'd3, 7'd0, "R1");
    send(32'h2000_0FFF, 8'd3, 7'd0, "R1");
    send(32'h2000_1000, 8'd3, 7'd0, "R2");
    send(32'h2001_FFFF, 8'd3, 7'd0, "R2");
    idle(1);
    // R3/R4: flash, watermark 16 -> secure below base+0x22000
    send(32'h1002_1FFF, 8'd0, 7'd16, "R3");
    send(32'h1000_0000, 8'd0, 7'd16, "R3");
    send(32'h1002_2000, 8'd0, 7'd16, "R4");
    send(32'h100F_FFFF, 8'd0, 7'd16, "R4");
    // R5: watermark 0 keeps one granule
    send(32'h2000_03FF, 8'd0, 7'd0, "R5");
    send(32'h2000_0400, 8'd0, 7'd0, "R5");
    send(32'h1000_1FFF, 8'd0, 7'd0, "R5");
    send(32'h1000_2000, 8'd0, 7'd0, "R5");
    idle(2);
    // R6: boundary at or past the last address
    send(32'h2001_FFFF, 8'hFF, 7'h7F, "R6");
    send(32'h2001_FFFF, 8'h7F, 7'h7F, "R6");
    send(32'h2001_FFFF, 8'h7E, 7'h7F, "R6");
    send(32'h100F_FFFF, 8'hFF, 7'h7F, "R6");
    send(32'h100F_FFFF, 8'hFF, 7'h7E, "R6");
    // R7: outside both regions
    send(32'h2002_0000, 8'hFF, 7'h7F, "R7");
    send(32'h1FFF_FFFF, 8'hFF, 7'h7F, "R7");
    send(32'h1010_0000, 8'hFF, 7'h7F, "R7");
    send(32'h0FFF_FFFF, 8'hFF, 7'h7F, "R7");
    send(32'hFFFF_FFFF, 8'hFF, 7'h7F, "R7");
    idle(1);
    // R10: same address, watermark changes on consecutive cycles
    send(32'h2000_2400, 8'd9, 7'd1, "R10");
    send(32'h2000_2400, 8'd8, 7'd1, "R10");
    send(32'h2000_2400, 8'd9, 7'd1, "R10");
    send(32'h1000_4000, 8'd9, 7'd1, "R10");
    send(32'h1000_4000, 8'd9, 7'd2, "R10");
    idle(3);
    // mixed sweep, R8 with gaps
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: a = 32'h2000_0000 | {15'd0, lfsr[18:2]};
        2'd1: a = 32'h1000_0000 | {12'd0, lfsr[21:2]};
        2'd2: a = 32'h2000_0000 | {14'd0, lfsr[19:2]};
        default: a = lfsr;
      endcase
      send(a, lfsr[29:22], lfsr[31:25], "R8");
      if (lfsr[5]) idle(1);
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule